// File: doc/BRIEF.md
# DPLL Operating-Mode Controller

This block decides which operating mode a digital phase-locked loop runs in: free-run, lock acquisition, locked or holdover. It watches which references the monitors report as qualified, whether the reference now in use has failed, whether an alternative qualified reference exists, and whether the loop reports phase lock. From these it steps through the modes on its own, or it holds a mode that a two-bit select forces.

While the loop is locked, the controller keeps a running average of the loop's frequency word. When it moves into holdover it pulses a capture strobe and presents the stored average as the holdover frequency. That frequency stays constant for as long as holdover lasts. The mode is reported as a two-bit code, with separate lock and holdover indicator bits. The loop filter, the phase detector, the oscillator and the reference priority logic all sit outside this block.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, mode_o reads 0 (free-run), and lock_o, holdover_o and hold_capture_o are low. The mode codes are 0 free-run, 1 lock acquisition, 2 locked and 3 holdover.
- R2: In automatic selection, free-run moves to lock acquisition on the clock edge where any bit of qual_vec_i is high. Free-run is held while all bits are low.
- R3: Lock acquisition moves to locked on the edge where phase_lock_i is high.
- R4: In automatic selection, a locked controller that sees sel_fail_i high while alt_qual_i is high moves to lock acquisition.
- R5: In automatic selection, a locked controller that sees sel_fail_i high while alt_qual_i is low moves to holdover. Holdover is never entered automatically from any other mode.
- R6: In automatic selection, holdover moves to lock acquisition on the edge where any bit of qual_vec_i is high.
- R7: mode_sel_i is registered once before use: 00 automatic, 01 forced normal, 10 forced holdover, 11 forced free-run. The value present on the last edge of reset is the one that governs the first cycle after reset. Later changes take effect one cycle after they appear.
- R8: In forced normal, free-run and holdover move to lock acquisition, lock acquisition moves to locked on phase_lock_i, and the locked state ignores sel_fail_i.
- R9: Forced holdover enters holdover only if the controller has been locked at least once since reset. Without that history it stays in free-run.
- R10: Forced free-run moves to free-run on the next edge from any mode.
- R11: lock_o is high exactly when the mode is locked. holdover_o is high exactly when the mode is holdover.
- R12: On the edge that enters locked, the average is loaded with freq_word_i. On each edge while locked, it moves by (freq_word_i - average) arithmetically shifted right by AVG_SHIFT.
- R13: hold_capture_o is high for exactly the first cycle of each holdover stay. On that edge hold_freq_o takes the average as it stood just before the edge, and it does not change while holdover continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| qual_vec_i | input | NUM_REFS | Per-reference qualified flags from the monitors |
| sel_fail_i | input | 1 | The reference in use has failed |
| alt_qual_i | input | 1 | Another qualified reference is available to the selector |
| phase_lock_i | input | 1 | The loop reports phase lock achieved |
| mode_sel_i | input | 2 | Mode select: 00 auto, 01 normal, 10 holdover, 11 free-run |
| freq_word_i | input | FREQ_W | Current loop frequency word |
| mode_o | output | 2 | Current mode code |
| lock_o | output | 1 | Locked indicator |
| holdover_o | output | 1 | Holdover indicator |
| hold_capture_o | output | 1 | One-cycle strobe on entry to holdover |
| hold_freq_o | output | FREQ_W | Frequency word used during holdover |

## Verification
Mode state is a register that drives mode_o directly, so a wrong transition appears at the ports in the cycle after the edge that caused it. It then stays visible, because every later transition starts from the wrong mode. A history flag that is wrong shows up only when forced holdover is requested: the controller ends up in holdover or in free-run, and that is one cycle after the select is registered. A fault in the average shows up as a wrong hold_freq_o value in the first holdover cycle, which may come many locked cycles after the error was made. The reference model therefore compares the captured word on every holdover entry.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_ACQ  = 2'd1,
    MODE_LOCK = 2'd2,
    MODE_HOLD = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SEL_AUTO = 2'd0,
    SEL_NORM = 2'd1,
    SEL_HOLD = 2'd2,
    SEL_FREE = 2'd3
  } sel_e;
endpackage

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  sel_e  sel_i,
  input  logic  any_qual_i,
  input  logic  alt_qual_i,
  input  logic  sel_fail_i,
  input  logic  phase_lock_i,
  input  logic  hist_i,
  output mode_e state_o,
  output logic  enter_lock_o,
  output logic  enter_hold_o
);
  mode_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (sel_i)
      SEL_AUTO: begin
        unique case (st_q)
          MODE_FREE: if (any_qual_i) st_d = MODE_ACQ;
          MODE_ACQ:  if (phase_lock_i) st_d = MODE_LOCK;
          MODE_LOCK: if (sel_fail_i) st_d = alt_qual_i ? MODE_ACQ : MODE_HOLD;
          MODE_HOLD: if (any_qual_i) st_d = MODE_ACQ;
          default:   st_d = MODE_FREE;
        endcase
      end
      SEL_NORM: begin
        unique case (st_q)
          MODE_FREE, MODE_HOLD: st_d = MODE_ACQ;
          MODE_ACQ:  if (phase_lock_i) st_d = MODE_LOCK;
          default:   st_d = st_q;
        endcase
      end
      // no frequency history: holdover is meaningless, fall back to free-run
      SEL_HOLD: st_d = hist_i ? MODE_HOLD : MODE_FREE;
      default:  st_d = MODE_FREE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= MODE_FREE;
    else         st_q <= st_d;
  end

  assign state_o      = st_q;
  assign enter_lock_o = (st_d == MODE_LOCK) && (st_q != MODE_LOCK);
  assign enter_hold_o = (st_d == MODE_HOLD) && (st_q != MODE_HOLD);

  // R9
  hold_needs_hist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MODE_HOLD) |-> hist_i);
  // R5
  auto_hold_from_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MODE_HOLD && $past(st_q) != MODE_HOLD && $past(sel_i) == SEL_AUTO)
      |-> $past(st_q) == MODE_LOCK);
  // R2
  acq_needs_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MODE_ACQ && $past(st_q) == MODE_FREE && $past(sel_i) == SEL_AUTO)
      |-> $past(any_qual_i));
  // R10
  forced_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_FREE) |=> (st_q == MODE_FREE));
endmodule

// File: rtl/dpll_freq_hist.sv
module dpll_freq_hist #(
  parameter int unsigned FREQ_W    = 16,
  parameter int unsigned AVG_SHIFT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enter_lock_i,
  input  logic              locked_i,
  input  logic              enter_hold_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic              hist_o,
  output logic              cap_o,
  output logic [FREQ_W-1:0] hold_freq_o
);
  localparam int unsigned DW = FREQ_W + 1;

  logic [FREQ_W-1:0] avg_q, hold_q;
  logic              hist_q, cap_q;
  logic signed [DW-1:0] diff, step;

  assign diff = $signed({1'b0, freq_i}) - $signed({1'b0, avg_q});
  assign step = diff >>> AVG_SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avg_q  <= '0;
      hist_q <= 1'b0;
    end else if (enter_lock_i) begin
      avg_q  <= freq_i;
      hist_q <= 1'b1;
    end else if (locked_i) begin
      avg_q  <= avg_q + step[FREQ_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      cap_q <= enter_hold_i;
      if (enter_hold_i) hold_q <= avg_q;
    end
  end

  assign hist_o      = hist_q;
  assign cap_o       = cap_q;
  assign hold_freq_o = hold_q;

  // R12
  avg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_lock_i |=> (avg_q == $past(freq_i)));
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int unsigned NUM_REFS  = 8,
  parameter int unsigned FREQ_W    = 16,
  parameter int unsigned AVG_SHIFT = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REFS-1:0] qual_vec_i,
  input  logic                sel_fail_i,
  input  logic                alt_qual_i,
  input  logic                phase_lock_i,
  input  logic [1:0]          mode_sel_i,
  input  logic [FREQ_W-1:0]   freq_word_i,
  output logic [1:0]          mode_o,
  output logic                lock_o,
  output logic                holdover_o,
  output logic                hold_capture_o,
  output logic [FREQ_W-1:0]   hold_freq_o
);
  // sampled on every edge, reset or not, so the reset-time value is the default
  logic [1:0] sel_q;
  always_ff @(posedge clk_i) sel_q <= mode_sel_i;

  mode_e state;
  logic  enter_lock, enter_hold, hist;

  dpll_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_i        (sel_e'(sel_q)),
    .any_qual_i   (|qual_vec_i),
    .alt_qual_i   (alt_qual_i),
    .sel_fail_i   (sel_fail_i),
    .phase_lock_i (phase_lock_i),
    .hist_i       (hist),
    .state_o      (state),
    .enter_lock_o (enter_lock),
    .enter_hold_o (enter_hold)
  );

  dpll_freq_hist #(
    .FREQ_W    (FREQ_W),
    .AVG_SHIFT (AVG_SHIFT)
  ) u_hist (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enter_lock_i (enter_lock),
    .locked_i     (state == MODE_LOCK),
    .enter_hold_i (enter_hold),
    .freq_i       (freq_word_i),
    .hist_o       (hist),
    .cap_o        (hold_capture_o),
    .hold_freq_o  (hold_freq_o)
  );

  assign mode_o     = state;
  assign lock_o     = (state == MODE_LOCK);
  assign holdover_o = (state == MODE_HOLD);

  // R13
  cap_in_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_capture_o |-> holdover_o);
  // R13
  hold_word_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (holdover_o && $past(holdover_o)) |-> $stable(hold_freq_o));
  // R3
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(phase_lock_i));
endmodule

// File: tb/dpll_mode_ctrl_test.sv
module dpll_mode_ctrl_test;
  localparam int NR = 8;
  localparam int FW = 16;
  localparam int SH = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] qual = '0;
  logic          fail = 1'b0, alt = 1'b0, plock = 1'b0;
  logic [1:0]    msel = 2'b00;
  logic [FW-1:0] freq = '0;
  logic [1:0]    mode;
  logic          lock, hold, cap;
  logic [FW-1:0] hfreq;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  dpll_mode_ctrl #(.NUM_REFS(NR), .FREQ_W(FW), .AVG_SHIFT(SH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .qual_vec_i(qual), .sel_fail_i(fail),
    .alt_qual_i(alt), .phase_lock_i(plock), .mode_sel_i(msel),
    .freq_word_i(freq), .mode_o(mode), .lock_o(lock), .holdover_o(hold),
    .hold_capture_o(cap), .hold_freq_o(hfreq));

  // behavioural model
  int m_mode = 0, m_avg = 0, m_hf = 0, m_sel = 0;
  bit m_hist = 0, m_cap = 0;

  always @(posedge clk) begin
    int nx, so;
    so = m_sel;
    m_sel = msel;
    if (!rst_n) begin
      m_mode = 0; m_avg = 0; m_hf = 0; m_hist = 0; m_cap = 0;
    end else begin
      nx = m_mode;
      if (so == 0) begin
        if (m_mode == 0 && qual != 0) nx = 1;
        else if (m_mode == 1 && plock) nx = 2;
        else if (m_mode == 2 && fail) nx = alt ? 1 : 3;
        else if (m_mode == 3 && qual != 0) nx = 1;
      end else if (so == 1) begin
        if (m_mode == 0 || m_mode == 3) nx = 1;
        else if (m_mode == 1 && plock) nx = 2;
      end else if (so == 2) nx = m_hist ? 3 : 0;
      else nx = 0;
      m_cap = (nx == 3 && m_mode != 3);
      if (m_cap) m_hf = m_avg;
      if (nx == 2 && m_mode != 2) begin m_avg = freq; m_hist = 1; end
      else if (m_mode == 2) m_avg = m_avg + ((int'(freq) - m_avg) >>> SH);
      m_mode = nx;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    chk(mode == m_mode[1:0], "mode", mode, m_mode);
    chk(lock == (m_mode == 2), "R11 lock", lock, m_mode == 2);
    chk(hold == (m_mode == 3), "R11 holdover", hold, m_mode == 3);
    chk(cap == m_cap, "R13 capture", cap, m_cap);
    chk(hfreq == m_hf[FW-1:0], "R12 hold word", hfreq, m_hf);
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk); rst_n = 0; msel = s;
    cyc(3);
    rst_n = 1;
  endtask

  task automatic expect_mode(input int e, input string why);
    @(negedge clk);
    chk(mode == e[1:0], why, mode, e);
    cyc(0);
  endtask

  initial begin
    // R1 reset state
    tag = "R1";
    cyc(3); rst_n = 1;
    @(negedge clk);
    chk(mode == 0 && !lock && !hold && !cap, "R1 reset outputs", mode, 0);
    // R2 idle while unqualified
    tag = "R2"; cyc(4); expect_mode(0, "R2 no qual stays free");
    qual = 8'h10; cyc(1); expect_mode(1, "R2 qual starts acquisition");
    // R3
    tag = "R3"; cyc(3); plock = 1; cyc(1); plock = 0;
    expect_mode(2, "R3 locked on phase lock");
    for (int i = 0; i < 20; i++) begin freq = 16'(1000 + i * 37); cyc(1); end
    // R4
    tag = "R4"; alt = 1; fail = 1; cyc(1); fail = 0;
    expect_mode(1, "R4 alt ref -> acquisition");
    plock = 1; freq = 16'd5000; cyc(1); plock = 0;
    for (int i = 0; i < 15; i++) begin freq = 16'(5000 - i * 53); cyc(1); end
    // R5
    tag = "R5"; alt = 0; qual = 0; fail = 1; cyc(1); fail = 0;
    @(negedge clk); chk(hold && cap, "R5 holdover with strobe", mode, 3);
    cyc(5); expect_mode(3, "R13 holdover held");
    // R6
    tag = "R6"; qual = 8'h01; cyc(1); expect_mode(1, "R6 requal -> acquisition");
    // R8 forced normal ignores failures
    tag = "R8"; msel = 2'b01; plock = 1; cyc(2); plock = 0;
    fail = 1; cyc(3); fail = 0; expect_mode(2, "R8 forced normal ignores fail");
    // R9 forced holdover with history
    tag = "R9"; qual = 0; msel = 2'b10; freq = 16'd60000; cyc(2);
    expect_mode(3, "R9 forced holdover");
    // R10
    tag = "R10"; msel = 2'b11; cyc(2); expect_mode(0, "R10 forced free");
    // forced normal from free, then auto hold with large upward word
    tag = "R12"; msel = 2'b01; qual = 8'h80; cyc(2); plock = 1; freq = 16'd100; cyc(1);
    plock = 0; msel = 2'b00;
    for (int i = 0; i < 12; i++) begin freq = 16'd65000; cyc(1); end
    qual = 0; alt = 0; fail = 1; cyc(1); fail = 0; cyc(3);
    // R7 / R9 reset-time select, no history
    tag = "R7"; qual = 8'hFF; do_reset(2'b10);
    expect_mode(0, "R9 forced hold w/o history stays free");
    cyc(3);
    do_reset(2'b11); cyc(3); expect_mode(0, "R7 latched forced free");
    msel = 2'b00; cyc(1); expect_mode(0, "R7 one cycle of select latency");
    cyc(1); expect_mode(1, "R7 auto takes effect");
    cyc(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule